// File: doc/BRIEF.md
# Shared RAM Cycle Arbiter

This block lets two processors take turns on one single-ported RAM. One side is a host processor that makes a request and waits for a data acknowledge. The other side is a local 8-bit processor that makes a request and is held off by a wait line. The arbiter samples both request lines once per sampling period. It gives one memory cycle to one requester and drives the RAM chip-select, the write-enable and the data transceiver enable and direction for that cycle.

A cycle runs through five states: idle, grant, access, done and release. In the done state the arbiter stays put for as long as the granted processor keeps its request high. Only after that request falls does it release the transceivers and return to idle. When both sides ask at the same sampling point, the host wins. The host bus is wider than the RAM. Only its low byte lane takes part in transfers, and the upper read lanes return zero.

Top module: `shmem_arbiter`

## Requirements
- R1: State changes happen only at clock edges where `sys_div` is low (the sampling tick). At any edge where `sys_div` is high, every output holds its value.
- R2: Directly after reset, `ram_cs`, `ram_we`, `xcvr_en`, `ram_dir`, `host_dtack`, `loc_wait` and `busy` are all 0, and both read-data outputs are 0.
- R3: `busy` is 0 only in idle. It is 1 from the grant state through the release state.
- R4: At an idle tick, if the synchronized host request is high, the host is granted even when a local request is also pending. Otherwise a pending local request is granted. The granted side's address, direction and write data are captured at that tick.
- R5: `ram_cs` and `xcvr_en` are 1 in the grant, access and done states. `ram_we` is 1 only in the access state of a write cycle and is 0 again in done.
- R6: `ram_dir` is 1 for a read (data flows from the RAM to the requester) and 0 for a write. It follows `host_rnw` (1 = read) for a host cycle and `loc_rd` (1 = read) for a local cycle, both captured at the grant. It is 0 whenever `xcvr_en` is 0.
- R7: `host_dtack` is 1 only in the done state of a host-owned cycle, at least one sampling period after `ram_cs` rose. A local cycle never raises it.
- R8: The done state holds for as long as the owner's synchronized request is high. After that request falls, the first tick moves to release, where chip-select and the transceivers are off, and the next tick moves to idle.
- R9: `loc_wait` is 1 whenever the synchronized local request is high and the arbiter is not in the done state of a local-owned cycle.
- R10: Read data is taken from `ram_rdata` at the tick that leaves the access state of a read, and only into the owner's output. `host_rdata` carries it in its low 8 bits with the upper bits 0. `ram_wdata` drives the captured write byte.
- R11: Each request passes through a SYNC_STAGES-flop synchronizer before the state machine sees it. With the default of 2, `busy` is still 0 at the second edge after a request rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_div | input | 1 | Divided system clock; low marks a sampling edge |
| host_req | input | 1 | Host memory request (asynchronous) |
| host_rnw | input | 1 | Host direction, 1 = read |
| host_addr | input | AW | Host address |
| host_wdata | input | RAM_DW | Host write data, low byte lane |
| host_rdata | output | HOST_DW | Host read data, upper lanes zero |
| host_dtack | output | 1 | Data acknowledge to host |
| loc_req | input | 1 | Local memory request (asynchronous) |
| loc_rd | input | 1 | Local read strobe, 1 = read |
| loc_addr | input | AW | Local address |
| loc_wdata | input | RAM_DW | Local write data |
| loc_rdata | output | RAM_DW | Local read data |
| loc_wait | output | 1 | Holds off the local processor |
| ram_cs | output | 1 | RAM chip-select |
| ram_we | output | 1 | RAM write-enable |
| ram_dir | output | 1 | Transceiver direction, 1 = RAM to requester |
| xcvr_en | output | 1 | Transceiver enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | RAM_DW | RAM write data |
| ram_rdata | input | RAM_DW | RAM read data |
| busy | output | 1 | Memory cycle in progress |

## Verification
The in-line assertions check, on every cycle, the rules that hold in any single clock step:
- the state is frozen on edges without a tick;
- the host wins a simultaneous idle tick;
- the done state is held while the owner still requests;
- write-enable lies inside chip-select;
- the acknowledge follows chip-select;
- the local processor is held in wait during a host acknowledge;
- the direction is stable within a window.

Only the bench's scenarios can show the rest:
- that the right byte ends up in the right requester's read register;
- that upper host lanes read as zero;
- that the synchronizer latency holds;
- that a stalled divided clock freezes a whole cycle mid-flight.

A contended sequence, in which a local request waits through a complete host cycle and then gets its own, is also covered only by the bench.

// File: rtl/shm_pkg.sv
package shm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_GRANT   = 3'd1,
        ST_ACCESS  = 3'd2,
        ST_DONE    = 3'd3,
        ST_RELEASE = 3'd4
    } cyc_state_t;

    // Access-select level: low selects the host, high defaults to local.
    typedef enum logic {
        OWN_HOST  = 1'b0,
        OWN_LOCAL = 1'b1
    } owner_t;

    // True while the RAM and transceivers belong to the granted side.
    function automatic logic in_window(cyc_state_t s);
        return (s == ST_GRANT) || (s == ST_ACCESS) || (s == ST_DONE);
    endfunction

    // Request level of whichever side owns the current cycle.
    function automatic logic owner_holds(owner_t o, logic h, logic l);
        return (o == OWN_HOST) ? h : l;
    endfunction

    // Fixed host priority: a host request drives the select input low.
    function automatic owner_t access_select(logic host_seen);
        return host_seen ? OWN_HOST : OWN_LOCAL;
    endfunction

endpackage

// File: rtl/shm_sampler.sv
module shm_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sys_div,
    input  logic host_req,
    input  logic loc_req,
    output logic tick,
    output logic host_req_s,
    output logic loc_req_s
);
    logic [SYNC_STAGES-1:0] h_pipe;
    logic [SYNC_STAGES-1:0] l_pipe;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    h_pipe <= '0;
                    l_pipe <= '0;
                end else begin
                    h_pipe[0] <= host_req;
                    l_pipe[0] <= loc_req;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    h_pipe <= '0;
                    l_pipe <= '0;
                end else begin
                    h_pipe <= {h_pipe[SYNC_STAGES-2:0], host_req};
                    l_pipe <= {l_pipe[SYNC_STAGES-2:0], loc_req};
                end
            end
        end
    endgenerate

    assign host_req_s = h_pipe[SYNC_STAGES-1];
    assign loc_req_s  = l_pipe[SYNC_STAGES-1];
    // Sampling happens on every other edge: those where the divided clock is low.
    assign tick       = ~sys_div;
endmodule

// File: rtl/shm_cycle_fsm.sv
module shm_cycle_fsm
    import shm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       host_req_s,
    input  logic       loc_req_s,
    output cyc_state_t state,
    output owner_t     owner,
    output owner_t     sel_owner,
    output logic       grant_load
);
    cyc_state_t nxt;

    assign sel_owner  = access_select(host_req_s);
    assign grant_load = tick && (state == ST_IDLE) && (host_req_s || loc_req_s);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (grant_load) nxt = ST_GRANT;
            ST_GRANT:   if (tick) nxt = ST_ACCESS;
            ST_ACCESS:  if (tick) nxt = ST_DONE;
            ST_DONE:    if (tick && !owner_holds(owner, host_req_s, loc_req_s)) nxt = ST_RELEASE;
            ST_RELEASE: if (tick) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            owner <= OWN_HOST;
        end else begin
            state <= nxt;
            if (grant_load) owner <= sel_owner;
        end
    end

    a_r1_frozen_off_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(state));

    a_r4_host_wins: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && tick && host_req_s) |=> (owner == OWN_HOST && state == ST_GRANT));

    a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && owner_holds(owner, host_req_s, loc_req_s)) |=> (state == ST_DONE));

    a_r8_release_to_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RELEASE && tick) |=> (state == ST_IDLE));
endmodule

// File: rtl/shm_datapath.sv
module shm_datapath
    import shm_pkg::*;
#(
    parameter int AW      = 8,
    parameter int RAM_DW  = 8,
    parameter int HOST_DW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  cyc_state_t         state,
    input  owner_t             owner,
    input  owner_t             sel_owner,
    input  logic               grant_load,
    input  logic               loc_req_s,
    input  logic               host_rnw,
    input  logic [AW-1:0]      host_addr,
    input  logic [RAM_DW-1:0]  host_wdata,
    input  logic               loc_rd,
    input  logic [AW-1:0]      loc_addr,
    input  logic [RAM_DW-1:0]  loc_wdata,
    input  logic [RAM_DW-1:0]  ram_rdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic [RAM_DW-1:0]  loc_rdata,
    output logic               host_dtack,
    output logic               loc_wait,
    output logic               ram_cs,
    output logic               ram_we,
    output logic               ram_dir,
    output logic               xcvr_en,
    output logic [AW-1:0]      ram_addr,
    output logic [RAM_DW-1:0]  ram_wdata,
    output logic               busy
);
    localparam int PAD = HOST_DW - RAM_DW;

    logic [AW-1:0]     addr_q;
    logic [RAM_DW-1:0] wdata_q;
    logic              rd_q;
    logic [RAM_DW-1:0] host_rd_q;
    logic [RAM_DW-1:0] loc_rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rd_q      <= 1'b0;
            host_rd_q <= '0;
            loc_rd_q  <= '0;
        end else begin
            if (grant_load) begin
                if (sel_owner == OWN_HOST) begin
                    addr_q  <= host_addr;
                    wdata_q <= host_wdata;
                    rd_q    <= host_rnw;
                end else begin
                    addr_q  <= loc_addr;
                    wdata_q <= loc_wdata;
                    rd_q    <= loc_rd;
                end
            end
            if (tick && state == ST_ACCESS && rd_q) begin
                if (owner == OWN_HOST) host_rd_q <= ram_rdata;
                else                   loc_rd_q  <= ram_rdata;
            end
        end
    end

    assign ram_cs     = in_window(state);
    assign xcvr_en    = in_window(state);
    assign ram_we     = (state == ST_ACCESS) && !rd_q;
    assign ram_dir    = in_window(state) && rd_q;
    assign busy       = (state != ST_IDLE);
    assign host_dtack = (state == ST_DONE) && (owner == OWN_HOST);
    assign loc_wait   = loc_req_s && !((state == ST_DONE) && (owner == OWN_LOCAL));
    assign ram_addr   = addr_q;
    assign ram_wdata  = wdata_q;
    assign host_rdata = {{PAD{1'b0}}, host_rd_q};
    assign loc_rdata  = loc_rd_q;

    a_r5_we_inside_cs: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ram_cs);

    a_r7_dtack_after_cs: assert property (@(posedge clk) disable iff (rst)
        $rose(host_dtack) |-> $past(ram_cs));

    a_r9_wait_during_host: assert property (@(posedge clk) disable iff (rst)
        (host_dtack && loc_req_s) |-> loc_wait);

    a_r3_cs_means_busy: assert property (@(posedge clk) disable iff (rst)
        ram_cs |-> busy);

    a_r6_dir_steady: assert property (@(posedge clk) disable iff (rst)
        (ram_cs && $past(ram_cs)) |-> $stable(ram_dir));
endmodule

// File: rtl/shmem_arbiter.sv
module shmem_arbiter
    import shm_pkg::*;
#(
    parameter int AW          = 8,
    parameter int RAM_DW      = 8,
    parameter int HOST_DW     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sys_div,
    input  logic               host_req,
    input  logic               host_rnw,
    input  logic [AW-1:0]      host_addr,
    input  logic [RAM_DW-1:0]  host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               host_dtack,
    input  logic               loc_req,
    input  logic               loc_rd,
    input  logic [AW-1:0]      loc_addr,
    input  logic [RAM_DW-1:0]  loc_wdata,
    output logic [RAM_DW-1:0]  loc_rdata,
    output logic               loc_wait,
    output logic               ram_cs,
    output logic               ram_we,
    output logic               ram_dir,
    output logic               xcvr_en,
    output logic [AW-1:0]      ram_addr,
    output logic [RAM_DW-1:0]  ram_wdata,
    input  logic [RAM_DW-1:0]  ram_rdata,
    output logic               busy
);
    logic       tick;
    logic       host_req_s;
    logic       loc_req_s;
    cyc_state_t state;
    owner_t     owner;
    owner_t     sel_owner;
    logic       grant_load;

    shm_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst        (rst),
        .sys_div    (sys_div),
        .host_req   (host_req),
        .loc_req    (loc_req),
        .tick       (tick),
        .host_req_s (host_req_s),
        .loc_req_s  (loc_req_s)
    );

    shm_cycle_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .host_req_s (host_req_s),
        .loc_req_s  (loc_req_s),
        .state      (state),
        .owner      (owner),
        .sel_owner  (sel_owner),
        .grant_load (grant_load)
    );

    shm_datapath #(.AW(AW), .RAM_DW(RAM_DW), .HOST_DW(HOST_DW)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .state      (state),
        .owner      (owner),
        .sel_owner  (sel_owner),
        .grant_load (grant_load),
        .loc_req_s  (loc_req_s),
        .host_rnw   (host_rnw),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .loc_rd     (loc_rd),
        .loc_addr   (loc_addr),
        .loc_wdata  (loc_wdata),
        .ram_rdata  (ram_rdata),
        .host_rdata (host_rdata),
        .loc_rdata  (loc_rdata),
        .host_dtack (host_dtack),
        .loc_wait   (loc_wait),
        .ram_cs     (ram_cs),
        .ram_we     (ram_we),
        .ram_dir    (ram_dir),
        .xcvr_en    (xcvr_en),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .busy       (busy)
    );

    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ram_cs && !ram_we && !xcvr_en && !host_dtack));
endmodule

// File: tb/sim_shmem_arbiter.sv
`timescale 1ns/1ps
module sim_shmem_arbiter;
    localparam int AW = 8, RDW = 8, HDW = 16, SYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sys_div = 1'b0;
    logic div_hold = 1'b0;
    logic host_req = 1'b0, host_rnw = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [RDW-1:0] host_wdata = '0;
    logic [HDW-1:0] host_rdata;
    logic host_dtack;
    logic loc_req = 1'b0, loc_rd = 1'b0;
    logic [AW-1:0] loc_addr = '0;
    logic [RDW-1:0] loc_wdata = '0;
    logic [RDW-1:0] loc_rdata;
    logic loc_wait, ram_cs, ram_we, ram_dir, xcvr_en, busy;
    logic [AW-1:0] ram_addr;
    logic [RDW-1:0] ram_wdata;
    logic [RDW-1:0] ram_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    // Stand-in RAM: read byte is a fixed function of the address.
    assign ram_rdata = ram_addr ^ 8'h5A;

    shmem_arbiter #(.AW(AW), .RAM_DW(RDW), .HOST_DW(HDW), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst(rst), .sys_div(sys_div),
        .host_req(host_req), .host_rnw(host_rnw), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_dtack(host_dtack),
        .loc_req(loc_req), .loc_rd(loc_rd), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .loc_wait(loc_wait),
        .ram_cs(ram_cs), .ram_we(ram_we), .ram_dir(ram_dir), .xcvr_en(xcvr_en),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .busy(busy)
    );

    // Divided clock: toggles after each edge unless frozen.
    initial forever begin
        @(posedge clk);
        #1;
        if (!div_hold) sys_div = ~sys_div;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 grant, 2 access, 3 done, 4 release.
    int m_ph;
    int m_own;   // 0 host, 1 local
    logic [AW-1:0] m_addr;
    logic [RDW-1:0] m_wd, m_hrd, m_lrd;
    logic m_rd;
    logic hq [SYNC];
    logic lq [SYNC];

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_own = 0; m_addr = '0; m_wd = '0; m_rd = 1'b0;
            m_hrd = '0; m_lrd = '0;
            for (int i = 0; i < SYNC; i++) begin hq[i] = 1'b0; lq[i] = 1'b0; end
        end else begin
            if (!sys_div) begin
                if (m_ph == 0) begin
                    if (hq[SYNC-1]) begin
                        m_own = 0; m_addr = host_addr; m_wd = host_wdata; m_rd = host_rnw; m_ph = 1;
                    end else if (lq[SYNC-1]) begin
                        m_own = 1; m_addr = loc_addr; m_wd = loc_wdata; m_rd = loc_rd; m_ph = 1;
                    end
                end else if (m_ph == 1) m_ph = 2;
                else if (m_ph == 2) begin
                    if (m_rd) begin
                        if (m_own == 0) m_hrd = m_addr ^ 8'h5A;
                        else            m_lrd = m_addr ^ 8'h5A;
                    end
                    m_ph = 3;
                end else if (m_ph == 3) begin
                    if (!((m_own == 0) ? hq[SYNC-1] : lq[SYNC-1])) m_ph = 4;
                end else m_ph = 0;
            end
            for (int i = SYNC - 1; i > 0; i--) begin hq[i] = hq[i-1]; lq[i] = lq[i-1]; end
            hq[0] = host_req; lq[0] = loc_req;
        end
    end

    // Every-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (started && !rst) begin
            automatic bit win = (m_ph >= 1 && m_ph <= 3);
            chk("R5 ram_cs", ram_cs, win);
            chk("R5 xcvr_en", xcvr_en, win);
            chk("R5 ram_we", ram_we, (m_ph == 2) && !m_rd);
            chk("R3 busy", busy, m_ph != 0);
            chk("R6 ram_dir", ram_dir, win && m_rd);
            chk("R7 host_dtack", host_dtack, (m_ph == 3) && (m_own == 0));
            chk("R9 loc_wait", loc_wait, lq[SYNC-1] && !((m_ph == 3) && (m_own == 1)));
            chk("R4 ram_addr", ram_addr, m_addr);
            chk("R10 ram_wdata", ram_wdata, m_wd);
            chk("R10 host_rdata", host_rdata, {8'h00, m_hrd});
            chk("R10 loc_rdata", loc_rdata, m_lrd);
        end
    end

    task automatic host_op(input logic [AW-1:0] a, input logic rnw, input logic [RDW-1:0] wd, input int hold);
        @(posedge clk); #1;
        host_addr = a; host_rnw = rnw; host_wdata = wd; host_req = 1'b1;
        while (!host_dtack) @(negedge clk);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R8 dtack held while request high", host_dtack, 1'b1);
        end
        if (rnw) chk("R10 host read byte and zero upper lanes", host_rdata, {8'h00, a ^ 8'h5A});
        @(posedge clk); #1;
        host_req = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic loc_op(input logic [AW-1:0] a, input logic rd, input logic [RDW-1:0] wd);
        @(posedge clk); #1;
        loc_addr = a; loc_rd = rd; loc_wdata = wd; loc_req = 1'b1;
        while (!loc_wait) @(negedge clk);
        while (loc_wait) @(negedge clk);
        if (rd) chk("R10 local read byte", loc_rdata, a ^ 8'h5A);
        @(posedge clk); #1;
        loc_req = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        started = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 reset cs/we/xcvr/dir", {ram_cs, ram_we, xcvr_en, ram_dir}, 4'b0);
        chk("R2 reset dtack/wait/busy", {host_dtack, loc_wait, busy}, 3'b0);
        chk("R2 reset read data", {host_rdata, loc_rdata}, 24'h0);

        // R11 synchronizer latency: busy still low after two edges.
        @(posedge clk); #1;
        host_addr = 8'h10; host_rnw = 1'b1; host_req = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R11 busy low within sync latency", busy, 1'b0);
        while (!host_dtack) @(negedge clk);
        @(posedge clk); #1 host_req = 1'b0;
        while (busy) @(negedge clk);

        host_op(8'h22, 1'b1, 8'h00, 0);
        host_op(8'h33, 1'b0, 8'hC4, 3);
        loc_op(8'h44, 1'b1, 8'h00);
        loc_op(8'h55, 1'b0, 8'h7E);
        host_op(8'h66, 1'b1, 8'h00, 12);

        // R4 simultaneous requests: host first, local waits through it.
        fork
            host_op(8'h70, 1'b1, 8'h00, 4);
            loc_op(8'h71, 1'b1, 8'h00);
            begin
                while (!ram_cs) @(negedge clk);
                chk("R4 host owns first contended cycle", ram_addr, 8'h70);
                chk("R9 local held while host owns", loc_wait, 1'b1);
            end
        join

        // R1 frozen divided clock mid-cycle.
        fork
            host_op(8'h80, 1'b0, 8'h99, 2);
            begin
                automatic logic [4:0] snap;
                while (!(ram_cs && sys_div)) @(negedge clk);
                div_hold = 1'b1;
                snap = {ram_cs, ram_we, host_dtack, busy, ram_dir};
                for (int i = 0; i < 6; i++) begin
                    @(negedge clk);
                    chk("R1 outputs frozen without tick", {ram_cs, ram_we, host_dtack, busy, ram_dir}, snap);
                end
                div_hold = 1'b0;
            end
        join

        // R7 local cycle never acknowledges the host; mixed pattern.
        for (int k = 0; k < 4; k++) begin
            loc_op(8'hA0 + k[7:0], k[0], 8'h10 + k[7:0]);
            host_op(8'hB0 + k[7:0], ~k[0], 8'h20 + k[7:0], k);
        end
        chk("R7 no dtack at rest", host_dtack, 1'b0);

        repeat (10) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule